// File: doc/BRIEF.md
# RC4 Byte Stream Cipher Engine

This block encrypts or decrypts a byte stream with the RC4 keystream. The key bytes are written into a small key store, and a key-size register says how many of them feed the key schedule. A start pulse, together with three mode inputs, picks how the 256-entry substitution table is prepared for a run:

- **Scramble:** the table is scrambled from the key.
- **Keep:** the table and its two indices are kept from the previous run.
- **Load:** a saved context is loaded from the input stream.

Data then flows through the block. Each accepted input byte produces one output byte equal to the input byte XORed with the next keystream byte. A byte marked last ends the run. After that, the whole context can be pushed out on the output stream.

Both byte streams use valid/ready handshakes. A byte moves when valid and ready are both high at a rising clock edge.

- **Input:** the block raises `in_ready` only while it loads a context, or while it ciphers and its one-entry output register is empty or being emptied in the same cycle.
- **Output:** the output register holds `out_data` steady for as long as `out_valid` is high and `out_ready` is low.

Misuse stops the engine and raises a sticky flag that only reset clears. Misuse means starting a key schedule with an illegal key size, or rewriting the key-size register while a run is active.

Top module: `rc4_engine`

## Requirements
- R1: After reset, `out_valid`, `in_ready`, `done`, `ksz_err` and `ctx_err` are low and the key-size register holds 0.
- R2: With `mode_no_perm`=0, start fills the table with S[n]=n and then runs 256 swap steps with j = j + S[i] + key[i mod K], where K (1..16) is the key-size register. Only key bytes 0..K-1 are used. For example, key 4B 65 79 with data "Plaintext" gives BB F3 16 E8 D9 40 AF 0A D3.
- R3: The cipher step is i=i+1, j=j+S[i], swap S[i] and S[j], output = data XOR S[S[i]+S[j]]. Transfers obey valid/ready, and the output byte stays stable while it is stalled.
- R4: When an accepted input byte has `in_last`=1, `done` rises once the last output byte has been accepted. `done` falls on the next start.
- R5: A start with `mode_no_perm`=0 and a key size of 0 or above 16 sets `ksz_err`. No output follows, and the engine ignores start and takes no input until reset.
- R6: Writing the key-size register while a run is active sets `ctx_err` and halts the engine with no further output until reset.
- R7: An `init` pulse clears the key-size register to 0.
- R8: With `mode_no_perm`=1 and `mode_ctx_src`=0, the run continues from the table and indices left by the previous run, and the key size is not checked.
- R9: With `mode_no_perm`=1 and `mode_ctx_src`=1, the first 258 input bytes are loaded as S[0]..S[255], then i, then j, before ciphering. `in_last` is ignored during the load.
- R10: With `mode_dump`=1 at start, after `done` rises the engine outputs 258 bytes: S[0]..S[255], then i, then j.
- R11: `mode_ctx_src` has no effect when `mode_no_perm`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Clears the key-size register |
| ksz_we | input | 1 | Key-size register write strobe |
| ksz_wdata | input | 5 | Key-size write value |
| key_we | input | 1 | Key byte write strobe |
| key_addr | input | 4 | Key byte index |
| key_wdata | input | 8 | Key byte value |
| start | input | 1 | Begin a run (accepted when idle) |
| mode_ctx_src | input | 1 | Load the context from the input stream (only when not permuting) |
| mode_dump | input | 1 | Push the context out after the run |
| mode_no_perm | input | 1 | Skip the key schedule |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final data byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| done | output | 1 | Run finished |
| ksz_err | output | 1 | Illegal key size at start (sticky) |
| ctx_err | output | 1 | Key size rewritten mid-run (sticky) |

## Verification
The bench aims at the cipher step when i and j coincide, and at the output index landing on one of the two just-swapped entries. A design that reads the table before the swap instead of after it gives wrong bytes on long streams and on a loaded context. It checks the key wrap for sizes 1, 3, 5 and 16 with junk written beyond the key size: an off-by-one wrap, or reading past K, corrupts the whole keystream. It checks random back-pressure, where a design that overwrites a stalled byte drops or repeats output. It checks the 258-byte load and dump order, and that the error flags are sticky, since a design that resumes after an error would emit bytes it must not.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
  localparam int SB_N = 256;
  localparam int CTX_N = SB_N + 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_KSA, ST_LOAD, ST_RUN, ST_FLUSH, ST_DUMP, ST_ERR
  } rc4_st_e;
endpackage

// File: rtl/rc4_keystore.sv
module rc4_keystore #(
  parameter int KEY_MAX = 16,
  parameter int KSZ_W   = 5,
  localparam int KA_W   = $clog2(KEY_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             ksz_we,
  input  logic [KSZ_W-1:0] ksz_wdata,
  input  logic             lock,
  input  logic             key_we,
  input  logic [KA_W-1:0]  key_addr,
  input  logic [7:0]       key_wdata,
  input  logic [KA_W-1:0]  rd_idx,
  output logic [7:0]       rd_byte,
  output logic [KSZ_W-1:0] ksize,
  output logic             ksz_ok
);
  logic [7:0] kmem [KEY_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < KEY_MAX; n++) kmem[n] <= '0;
      ksize <= '0;
    end else begin
      if (key_we) kmem[key_addr] <= key_wdata;
      if (init) ksize <= '0;
      else if (ksz_we && !lock) ksize <= ksz_wdata;
    end
  end

  assign rd_byte = kmem[rd_idx];
  assign ksz_ok  = (ksize != '0) && (ksize <= KSZ_W'(KEY_MAX));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ksz_we && lock && !init) |=> $stable(ksize));
endmodule

// File: rtl/rc4_sbox.sv
module rc4_sbox
  import rc4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fill,
  input  logic       swp_en,
  input  logic [7:0] swp_a,
  input  logic [7:0] swp_b,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] ra0,
  input  logic [7:0] ra1,
  input  logic [7:0] ra2,
  output logic [7:0] rd0,
  output logic [7:0] rd1,
  output logic [7:0] rd2
);
  logic [7:0] s [SB_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < SB_N; n++) s[n] <= 8'(n);
    end else if (fill) begin
      for (int n = 0; n < SB_N; n++) s[n] <= 8'(n);
    end else if (swp_en) begin
      s[swp_a] <= s[swp_b];
      s[swp_b] <= s[swp_a];
    end else if (wr_en) begin
      s[wr_addr] <= wr_data;
    end
  end

  assign rd0 = s[ra0];
  assign rd1 = s[ra1];
  assign rd2 = s[ra2];

  // R9
  sbox_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill, swp_en, wr_en}));
endmodule

// File: rtl/rc4_ctrl.sv
module rc4_ctrl
  import rc4_pkg::*;
#(
  parameter int KEY_MAX = 16,
  parameter int KSZ_W   = 5,
  localparam int KA_W   = $clog2(KEY_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_ctx_src,
  input  logic             mode_dump,
  input  logic             mode_no_perm,
  input  logic             ksz_we,
  input  logic             ksz_ok,
  input  logic [KSZ_W-1:0] ksize,
  input  logic [7:0]       key_byte,
  output logic [KA_W-1:0]  key_idx,
  output logic             busy,
  output logic             fill,
  output logic             swp_en,
  output logic [7:0]       swp_a,
  output logic [7:0]       swp_b,
  output logic             wr_en,
  output logic [7:0]       wr_addr,
  output logic [7:0]       wr_data,
  output logic [7:0]       ra0,
  output logic [7:0]       ra1,
  output logic [7:0]       ra2,
  input  logic [7:0]       rd0,
  input  logic [7:0]       rd1,
  input  logic [7:0]       rd2,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             done,
  output logic             ksz_err,
  output logic             ctx_err
);
  rc4_st_e          st;
  logic [7:0]       i, j;
  logic [KA_W-1:0]  kidx;
  logic [8:0]       cnt;
  logic             dump_q;

  logic [7:0]       i_nx, j_ksa, j_run, j_nx, t, ks, dump_byte;
  logic [KSZ_W-1:0] kidx_p1;
  logic             out_free, in_fire;

  always_comb begin
    i_nx    = i + 8'd1;
    ra0     = (st == ST_KSA) ? i : i_nx;
    j_ksa   = j + rd0 + key_byte;
    j_run   = j + rd0;
    j_nx    = (st == ST_KSA) ? j_ksa : j_run;
    ra1     = j_nx;
    t       = rd0 + rd1;
    ra2     = (st == ST_DUMP) ? cnt[7:0] : t;
    // table value at t after the swap of S[i_nx] and S[j_run]
    ks      = (t == i_nx) ? rd1 : ((t == j_run) ? rd0 : rd2);
    dump_byte = !cnt[8] ? rd2 : (cnt[0] ? j : i);
    kidx_p1 = KSZ_W'(kidx) + KSZ_W'(1);
  end

  assign out_free = !out_valid || out_ready;
  assign in_ready = (st == ST_LOAD) || ((st == ST_RUN) && out_free);
  assign in_fire  = in_valid && in_ready;
  assign busy     = (st != ST_IDLE) && (st != ST_ERR);
  assign key_idx  = kidx;
  assign fill     = (st == ST_FILL);
  assign swp_en   = (st == ST_KSA) || ((st == ST_RUN) && in_fire && !ksz_we);
  assign swp_a    = ra0;
  assign swp_b    = j_nx;
  assign wr_en    = (st == ST_LOAD) && in_fire && !cnt[8] && !ksz_we;
  assign wr_addr  = cnt[7:0];
  assign wr_data  = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; i <= '0; j <= '0; kidx <= '0; cnt <= '0;
      dump_q <= 1'b0; out_valid <= 1'b0; out_data <= '0;
      done <= 1'b0; ksz_err <= 1'b0; ctx_err <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (busy && ksz_we) begin
        st <= ST_ERR;
        ctx_err <= 1'b1;
      end else begin
        unique case (st)
          ST_IDLE: if (start) begin
            done   <= 1'b0;
            dump_q <= mode_dump;
            if (!mode_no_perm) begin
              if (!ksz_ok) begin
                st <= ST_ERR;
                ksz_err <= 1'b1;
              end else st <= ST_FILL;
            end else if (mode_ctx_src) begin
              st  <= ST_LOAD;
              cnt <= '0;
            end else st <= ST_RUN;
          end
          ST_FILL: begin
            i <= '0; j <= '0; kidx <= '0;
            st <= ST_KSA;
          end
          ST_KSA: begin
            i    <= i_nx;
            j    <= j_ksa;
            kidx <= (kidx_p1 == ksize) ? '0 : kidx + KA_W'(1);
            if (i == 8'hFF) begin
              st <= ST_RUN; i <= '0; j <= '0;
            end
          end
          ST_LOAD: if (in_fire) begin
            cnt <= cnt + 9'd1;
            if (cnt == 9'd256) i <= in_data;
            if (cnt == 9'd257) begin
              j  <= in_data;
              st <= ST_RUN;
            end
          end
          ST_RUN: if (in_fire) begin
            i <= i_nx;
            j <= j_run;
            out_data  <= in_data ^ ks;
            out_valid <= 1'b1;
            if (in_last) st <= ST_FLUSH;
          end
          ST_FLUSH: if (!out_valid) begin
            done <= 1'b1;
            if (dump_q) begin
              st <= ST_DUMP; cnt <= '0;
            end else st <= ST_IDLE;
          end
          ST_DUMP: if (out_free) begin
            out_data  <= dump_byte;
            out_valid <= 1'b1;
            cnt <= cnt + 9'd1;
            if (cnt == 9'd257) st <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R3
  run_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && (st == ST_RUN) && !ksz_we) |=> out_valid);
  // R2
  kidx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_KSA) |-> (KSZ_W'(kidx) < ksize));
  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ksz_err || ctx_err) && !out_valid) |=> !out_valid);
  // R4
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !out_valid);
endmodule

// File: rtl/rc4_engine.sv
module rc4_engine #(
  parameter int KEY_MAX = 16,
  parameter int KSZ_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init,
  input  logic                       ksz_we,
  input  logic [KSZ_W-1:0]           ksz_wdata,
  input  logic                       key_we,
  input  logic [$clog2(KEY_MAX)-1:0] key_addr,
  input  logic [7:0]                 key_wdata,
  input  logic                       start,
  input  logic                       mode_ctx_src,
  input  logic                       mode_dump,
  input  logic                       mode_no_perm,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  input  logic                       in_last,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_data,
  output logic                       done,
  output logic                       ksz_err,
  output logic                       ctx_err
);
  localparam int KA_W = $clog2(KEY_MAX);

  logic             busy, ksz_ok, fill, swp_en, wr_en;
  logic [KSZ_W-1:0] ksize;
  logic [KA_W-1:0]  key_idx;
  logic [7:0]       key_byte, swp_a, swp_b, wr_addr, wr_data;
  logic [7:0]       ra0, ra1, ra2, rd0, rd1, rd2;

  rc4_keystore #(.KEY_MAX(KEY_MAX), .KSZ_W(KSZ_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .init(init), .ksz_we(ksz_we),
    .ksz_wdata(ksz_wdata), .lock(busy), .key_we(key_we),
    .key_addr(key_addr), .key_wdata(key_wdata), .rd_idx(key_idx),
    .rd_byte(key_byte), .ksize(ksize), .ksz_ok(ksz_ok));

  rc4_sbox u_sbox (
    .clk(clk), .rst_n(rst_n), .fill(fill), .swp_en(swp_en),
    .swp_a(swp_a), .swp_b(swp_b), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ra0(ra0), .ra1(ra1), .ra2(ra2),
    .rd0(rd0), .rd1(rd1), .rd2(rd2));

  rc4_ctrl #(.KEY_MAX(KEY_MAX), .KSZ_W(KSZ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_ctx_src(mode_ctx_src),
    .mode_dump(mode_dump), .mode_no_perm(mode_no_perm), .ksz_we(ksz_we),
    .ksz_ok(ksz_ok), .ksize(ksize), .key_byte(key_byte), .key_idx(key_idx),
    .busy(busy), .fill(fill), .swp_en(swp_en), .swp_a(swp_a), .swp_b(swp_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ra0(ra0), .ra1(ra1), .ra2(ra2), .rd0(rd0), .rd1(rd1), .rd2(rd2),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done), .ksz_err(ksz_err), .ctx_err(ctx_err));
endmodule

// File: tb/rc4_engine_bench.sv
module rc4_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0, ksz_we = 1'b0, key_we = 1'b0, start = 1'b0;
  logic [4:0] ksz_wdata = '0;
  logic [3:0] key_addr = '0;
  logic [7:0] key_wdata = '0, in_data = '0, out_data;
  logic       mode_ctx_src = 1'b0, mode_dump = 1'b0, mode_no_perm = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic       in_ready, out_valid, done, ksz_err, ctx_err;

  rc4_engine u_rc4_engine (
    .clk(clk), .rst_n(rst_n), .init(init), .ksz_we(ksz_we),
    .ksz_wdata(ksz_wdata), .key_we(key_we), .key_addr(key_addr),
    .key_wdata(key_wdata), .start(start), .mode_ctx_src(mode_ctx_src),
    .mode_dump(mode_dump), .mode_no_perm(mode_no_perm),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done), .ksz_err(ksz_err), .ctx_err(ctx_err));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R1";
  logic [7:0] exq [$];
  bit bp_en = 1'b0;

  // behavioural reference state
  int ms [256];
  int mi = 0, mj = 0;
  int kb [16];
  int snap [256];
  int si, sj;

  function automatic void chk(string req, int act, int expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endfunction

  function automatic void m_ksa(int ks);
    int jj = 0;
    int tmp;
    for (int n = 0; n < 256; n++) ms[n] = n;
    for (int n = 0; n < 256; n++) begin
      jj = (jj + ms[n] + kb[n % ks]) & 255;
      tmp = ms[n]; ms[n] = ms[jj]; ms[jj] = tmp;
    end
    mi = 0; mj = 0;
  endfunction

  function automatic int m_ks();
    int tmp;
    mi = (mi + 1) & 255;
    mj = (mj + ms[mi]) & 255;
    tmp = ms[mi]; ms[mi] = ms[mj]; ms[mj] = tmp;
    return ms[(ms[mi] + ms[mj]) & 255];
  endfunction

  // output monitor: every accepted byte against the reference queue
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exq.size() == 0) chk({tag, " unexpected output"}, 1, 0);
      else chk({tag, " output byte"}, int'(out_data), int'(exq.pop_front()));
    end
  end

  initial forever begin
    @(posedge clk); #1;
    out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; exq.delete();
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr_ksz(int v);
    ksz_we = 1'b1; ksz_wdata = 5'(v); step(); ksz_we = 1'b0;
  endtask

  task automatic set_key(int ks);
    for (int n = 0; n < 16; n++) begin
      key_we = 1'b1; key_addr = 4'(n); key_wdata = 8'(kb[n]); step();
    end
    key_we = 1'b0;
    wr_ksz(ks);
  endtask

  task automatic go(bit ctx, bit dmp, bit np);
    mode_ctx_src = ctx; mode_dump = dmp; mode_no_perm = np;
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic push(int d, bit last);
    in_valid = 1'b1; in_data = 8'(d); in_last = last;
    do @(negedge clk); while (!in_ready);
    step();
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_model(int n, int seed);
    for (int k = 0; k < n; k++) begin
      int d = (k * 37 + seed) & 255;
      exq.push_back(8'(d ^ m_ks()));
      push(d, k == n - 1);
    end
  endtask

  task automatic wait_done(string req);
    int w = 0;
    while ((exq.size() != 0 || !done) && w < 20000) begin step(); w++; end
    chk({req, " run completes"}, int'(w < 20000), 1);
    chk({req, " done high"}, int'(done), 1);
  endtask

  task automatic quiet(string req, int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk({req, " no output"}, int'(out_valid), 0);
      chk({req, " no input"}, int'(in_ready), 0);
      step();
    end
  endtask

  initial begin
    int kv [9] = '{8'hBB, 8'hF3, 8'h16, 8'hE8, 8'hD9, 8'h40, 8'hAF, 8'h0A, 8'hD3};
    string pt = "Plaintext";
    do_reset();
    // R1: reset state at the ports
    tag = "R1";
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ksz_err", int'(ksz_err), 0);
    chk("R1 ctx_err", int'(ctx_err), 0);

    // R2: known vector, key size 3 with junk beyond the key
    tag = "R2";
    kb[0] = 'h4B; kb[1] = 'h65; kb[2] = 'h79;
    for (int n = 3; n < 16; n++) kb[n] = 'hA0 + n;
    set_key(3);
    m_ksa(3);
    go(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) begin
      void'(m_ks());
      exq.push_back(8'(kv[k]));
      push(int'(pt[k]), k == 8);
    end
    wait_done("R2 R4");

    // R8: continue from retained context, key size unchecked path
    tag = "R8";
    go(1'b0, 1'b0, 1'b1);
    send_model(20, 5);
    wait_done("R8");

    // R3 with back-pressure; R2 at key size 16
    tag = "R3";
    bp_en = 1'b1;
    for (int n = 0; n < 16; n++) kb[n] = (n * 29 + 7) & 255;
    set_key(16);
    m_ksa(16);
    go(1'b0, 1'b0, 1'b0);
    send_model(40, 11);
    wait_done("R3");

    // R10: dump after a key size 1 run
    tag = "R10";
    kb[0] = 'h5A;
    set_key(1);
    m_ksa(1);
    go(1'b0, 1'b1, 1'b0);
    send_model(10, 3);
    for (int n = 0; n < 256; n++) exq.push_back(8'(ms[n]));
    exq.push_back(8'(mi)); exq.push_back(8'(mj));
    wait_done("R10");
    bp_en = 1'b0;

    // R9: context loaded from the input stream, in_last ignored while loading
    tag = "R9";
    for (int n = 0; n < 16; n++) kb[n] = (n * 83 + 1) & 255;
    m_ksa(7);
    for (int k = 0; k < 5; k++) void'(m_ks());
    for (int n = 0; n < 256; n++) snap[n] = ms[n];
    si = mi; sj = mj;
    go(1'b1, 1'b0, 1'b1);
    for (int n = 0; n < 258; n++)
      push((n < 256) ? snap[n] : ((n == 256) ? si : sj), n == 100);
    send_model(12, 9);
    wait_done("R9");

    // R11: ctx_src ignored while permuting; R2 key size 5 with junk beyond
    tag = "R11";
    for (int n = 0; n < 16; n++) kb[n] = (n < 5) ? (n * 51 + 3) : 'hFF;
    set_key(5);
    m_ksa(5);
    go(1'b1, 1'b0, 1'b0);
    step();
    chk("R4 done cleared by start", int'(done), 0);
    send_model(8, 17);
    wait_done("R11");

    // R7: init clears key size, so a permuting start flags R5
    tag = "R7";
    init = 1'b1; step(); init = 1'b0;
    go(1'b0, 1'b0, 1'b0);
    chk("R7 cleared size rejected", int'(ksz_err), 1);
    wr_ksz(3);
    go(1'b0, 1'b0, 1'b0);
    quiet("R5 sticky", 4);
    chk("R5 flag held", int'(ksz_err), 1);

    // R5: size above 16; R1: size 0 after reset
    do_reset();
    tag = "R5";
    wr_ksz(17);
    go(1'b0, 1'b0, 1'b0);
    chk("R5 size 17", int'(ksz_err), 1);
    quiet("R5", 3);
    do_reset();
    go(1'b0, 1'b0, 1'b0);
    chk("R1 size zero after reset", int'(ksz_err), 1);

    // R6: key-size write during key schedule
    do_reset();
    tag = "R6";
    set_key(4);
    go(1'b0, 1'b0, 1'b0);
    repeat (10) step();
    wr_ksz(9);
    chk("R6 ctx_err", int'(ctx_err), 1);
    chk("R6 ksz_err stays low", int'(ksz_err), 0);
    repeat (300) step();
    quiet("R6", 3);
    chk("R6 done low", int'(done), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog %s actual=hung expected=finish", tag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule